// File: doc/BRIEF.md
# Two-Wire Write-Only DAC Code Loader

This block is a receive-only SMBus slave that sets a 10-bit current DAC code. It samples SCL and SDA with its own system clock and finds START and STOP conditions from those samples. It accepts only the Write Byte transaction:

- START;
- a 7-bit address, then a write bit;
- ACK;
- a command byte, then ACK;
- a data byte, then ACK;
- an optional STOP.

The block acknowledges by pulling SDA low. It never drives the line high, because pull-ups outside the block hold the idle level.

The value is loaded in two steps. The falling SCL edge that closes the command acknowledge loads the useful command bits into a staging register. The falling SCL edge that closes the data acknowledge copies the staged bits and the data byte into the output register. The new code therefore takes effect without any STOP. A START or STOP that arrives partway through a transaction abandons that transaction.

Top module: `dac_bus_loader`

## Requirements
- R1: After reset, `dacCode` is 0, `shutdown` is 0 and `sdaOe` is 0. While reset is held, the block does not respond to the bus.
- R2: When the address and write bit match, the block asserts `sdaOe`, pulling SDA low, during the ninth SCL clock of the address byte, the command byte and the data byte. It releases SDA on the falling SCL edge that ends each acknowledge.
- R3: Bytes arrive MSB first and are sampled on the rising edge of SCL. The committed `dacCode` is {command[1:0], data[7:0]}. Command bits 6 to 2 have no effect.
- R4: Command bit 7 is the shutdown flag. `shutdown` takes its value at the same moment as `dacCode`.
- R5: The output register changes only after the falling SCL edge that ends the data acknowledge, and that change needs no STOP.
- R6: An address byte whose upper five bits are not 01011, or whose next two bits differ from `addrSel[1:0]`, is not acknowledged. The block then ignores the bus until the next START, and the outputs keep their values.
- R7: An address byte whose lowest bit is 1 (a read request) is not acknowledged even when the address matches. The outputs keep their values.
- R8: A STOP, or a START, seen partway through a byte abandons the transaction and leaves the output register unchanged. A START begins a new address byte from any state, including a repeated START.
- R9: `sdaOe` changes only after a synchronized falling SCL edge, after a START or after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line as seen at the pad |
| sdaIn | input | 1 | SDA line as seen at the pad (wired-AND level) |
| addrSel | input | 2 | Two lowest bits of the slave address |
| sdaOe | output | 1 | High to pull SDA low (open-drain enable) |
| dacCode | output | 10 | Committed DAC output code |
| shutdown | output | 1 | Committed shutdown flag |

## Verification
The hardest case to reach from the pins is an abort in the middle of a transaction. The bench must first acknowledge the address and command bytes so that the staging register holds new bits. It must then break off partway through the data byte with a STOP, or with a repeated START that a full transaction follows. It checks that the first abort leaves the output unchanged and that the restart still commits. The ignore path after a refused address is reached by clocking the remaining bytes anyway and checking that no acknowledge appears and no output changes.

// File: rtl/dac_bus_pkg.sv
package dac_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_DATA, ST_DATA_ACK, ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftEn;
    logic loadStage;
    logic loadOut;
  } ctrlStrobe_t;
endpackage

// File: rtl/dac_bus_sync.sv
module dac_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclHigh,
  output logic sdaHigh,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  localparam int LINES = 2;
  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] syncLines;
  logic [LINES-1:0] prevLines;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawLines[g]};
    end
    assign syncLines[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '1;
    else       prevLines <= syncLines;
  end

  assign sclHigh   = syncLines[0];
  assign sdaHigh   = syncLines[1];
  assign sclRise   = syncLines[0] & ~prevLines[0];
  assign sclFall   = ~syncLines[0] & prevLines[0];
  assign startSeen = syncLines[0] & prevLines[0] & prevLines[1] & ~syncLines[1];
  assign stopSeen  = syncLines[0] & prevLines[0] & ~prevLines[1] & syncLines[1];
endmodule

// File: rtl/dac_bus_ctrl.sv
module dac_bus_ctrl
  import dac_bus_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startSeen,
  input  logic        stopSeen,
  input  logic        addrHit,
  output ctrlStrobe_t strb,
  output logic        ackDrive
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  busState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;
  logic ackHigh, ackHighNxt;
  logic byteFull, inByte, inAck;

  assign byteFull = (bitCnt == FULL);
  assign inByte   = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_DATA);
  assign inAck    = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK) || (state == ST_DATA_ACK);
  assign ackDrive = inAck;

  always_comb begin
    stateNxt   = state;
    bitCntNxt  = bitCnt;
    ackHighNxt = ackHigh;
    strb       = '0;
    if (startSeen) begin
      stateNxt   = ST_ADDR;
      bitCntNxt  = '0;
      ackHighNxt = 1'b0;
    end else if (stopSeen) begin
      stateNxt   = ST_IDLE;
      bitCntNxt  = '0;
      ackHighNxt = 1'b0;
    end else if (inByte) begin
      if (sclRise && !byteFull) begin
        strb.shiftEn = 1'b1;
        bitCntNxt    = bitCnt + 1'b1;
      end else if (sclFall && byteFull) begin
        bitCntNxt = '0;
        unique case (state)
          ST_ADDR: stateNxt = addrHit ? ST_ADDR_ACK : ST_IGNORE;
          ST_CMD:  stateNxt = ST_CMD_ACK;
          default: stateNxt = ST_DATA_ACK;
        endcase
      end
    end else if (inAck) begin
      if (sclRise) ackHighNxt = 1'b1;
      else if (sclFall && ackHigh) begin
        ackHighNxt = 1'b0;
        unique case (state)
          ST_ADDR_ACK: stateNxt = ST_CMD;
          ST_CMD_ACK: begin
            stateNxt       = ST_DATA;
            strb.loadStage = 1'b1;
          end
          default: begin
            stateNxt     = ST_IGNORE;
            strb.loadOut = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackHigh <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitCnt  <= bitCntNxt;
      ackHigh <= ackHighNxt;
    end
  end
endmodule

// File: rtl/dac_bus_datapath.sv
module dac_bus_datapath
  import dac_bus_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int          CODE_W   = 10,
  parameter int          SEL_W    = 2,
  parameter int          OFF_BIT  = 7,
  parameter logic [4:0]  ADDR_HI  = 5'b01011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaHigh,
  input  logic [SEL_W-1:0]  addrSel,
  input  ctrlStrobe_t       strb,
  output logic              addrHit,
  output logic [CODE_W-1:0] dacCode,
  output logic              shutdown
);
  localparam int HI_W = CODE_W - BYTE_W;

  logic [BYTE_W-1:0] shiftReg;
  logic [HI_W-1:0]   stageHi;
  logic              stageOff;

  assign addrHit = (shiftReg[BYTE_W-1:1] == {ADDR_HI, addrSel}) && !shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaHigh};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageHi  <= '0;
      stageOff <= 1'b0;
    end else if (strb.loadStage) begin
      stageHi  <= shiftReg[HI_W-1:0];
      stageOff <= shiftReg[OFF_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode  <= '0;
      shutdown <= 1'b0;
    end else if (strb.loadOut) begin
      dacCode  <= {stageHi, shiftReg};
      shutdown <= stageOff;
    end
  end
endmodule

// File: rtl/dac_bus_loader.sv
module dac_bus_loader
  import dac_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        addrSel,
  output logic              sdaOe,
  output logic [CODE_W-1:0] dacCode,
  output logic              shutdown
);
  localparam int BYTE_W = 8;

  logic sclHigh, sdaHigh, sclRise, sclFall, startSeen, stopSeen, addrHit;
  ctrlStrobe_t strb;

  dac_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclHigh(sclHigh), .sdaHigh(sdaHigh), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  dac_bus_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .addrHit(addrHit),
    .strb(strb), .ackDrive(sdaOe)
  );

  dac_bus_datapath #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdaHigh(sdaHigh), .addrSel(addrSel), .strb(strb),
    .addrHit(addrHit), .dacCode(dacCode), .shutdown(shutdown)
  );

  logic unusedSclHigh;
  assign unusedSclHigh = sclHigh;
endmodule

// File: rtl/dac_bus_checker.sv
module dac_bus_checker
  import dac_bus_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic [CODE_W-1:0] dacCode,
  input logic              shutdown,
  input ctrlStrobe_t       strb,
  input logic              sclFall,
  input logic              startSeen,
  input logic              stopSeen
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rstN |=> (dacCode == '0 && !shutdown && !sdaOe));

  // R5
  commit_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dacCode != $past(dacCode)) || (shutdown != $past(shutdown))) |-> $past(strb.loadOut));

  // R9
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(sclFall));

  // R9
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> $past(sclFall || startSeen || stopSeen));

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaOe);

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftEn, strb.loadStage, strb.loadOut}));
endmodule

bind dac_bus_loader dac_bus_checker #(.CODE_W(CODE_W)) chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .dacCode(dacCode), .shutdown(shutdown),
  .strb(strb), .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen)
);

// File: tb/dac_bus_loader_test.sv
module dac_bus_loader_test;
  localparam int Q = 10;

  typedef struct packed {
    logic [6:0] addr;
    logic       rw;
    logic [7:0] cmd;
    logic [7:0] data;
    logic [2:0] ack;
    logic [9:0] code;
    logic       off;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{7'b0101111, 1'b0, 8'h03, 8'hFF, 3'b111, 10'h3FF, 1'b0},
    '{7'b0101111, 1'b0, 8'h81, 8'h5A, 3'b111, 10'h15A, 1'b1},
    '{7'b0101111, 1'b0, 8'h7D, 8'h33, 3'b111, 10'h133, 1'b0},
    '{7'b0101110, 1'b0, 8'h82, 8'h11, 3'b000, 10'h133, 1'b0},
    '{7'b0101111, 1'b1, 8'h82, 8'h11, 3'b000, 10'h133, 1'b0},
    '{7'b0111111, 1'b0, 8'h80, 8'h00, 3'b000, 10'h133, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] addrSel = 2'b11;
  logic sdaOe;
  logic [9:0] dacCode;
  logic shutdown;
  logic sdaLine;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  dac_bus_loader uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaOe(sdaOe), .dacCode(dacCode), .shutdown(shutdown)
  );

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ(1);
      sclM = 1'b1; waitQ(2);
      sclM = 1'b0; waitQ(1);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    ack = ~sdaLine;
    waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic writeByte(input logic [6:0] a, input logic rw, input logic [7:0] c,
                           input logic [7:0] d, output logic [2:0] acks);
    logic k;
    busStart();
    sendByte({a, rw}, k); acks[2] = k;
    sendByte(c, k);       acks[1] = k;
    sendByte(d, k);       acks[0] = k;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    repeat (5) @(negedge clk);
    // R1: reset values while reset is held
    check("R1 code", dacCode, 0);
    check("R1 shutdown", shutdown, 0);
    check("R1 sdaOe", sdaOe, 0);
    rstN = 1'b1;
    waitQ(2);

    // Table: R2 ack pattern, R3/R4 code and flag, R6/R7 refusals
    for (int v = 0; v < NV; v++) begin
      writeByte(VECS[v].addr, VECS[v].rw, VECS[v].cmd, VECS[v].data, acks);
      check($sformatf("R2/R6/R7 ack vec%0d", v), acks, VECS[v].ack);
      // R5: checked before any STOP is sent
      check($sformatf("R3/R5 code vec%0d", v), dacCode, VECS[v].code);
      check($sformatf("R4 shutdown vec%0d", v), shutdown, VECS[v].off);
      check($sformatf("R2 released vec%0d", v), sdaOe, 0);
      busStop();
    end

    // R8: STOP partway through the data byte
    busStart();
    sendByte({7'b0101111, 1'b0}, acks[2]);
    sendByte(8'h81, acks[1]);
    sendBits(8'h00, 4);
    busStop();
    check("R8 stop abort code", dacCode, 10'h133);
    check("R8 stop abort shutdown", shutdown, 0);

    // R8: repeated START partway through the command byte, then a full write
    busStart();
    sendByte({7'b0101111, 1'b0}, acks[2]);
    sendBits(8'h81, 3);
    writeByte(7'b0101111, 1'b0, 8'h02, 8'h11, acks);
    check("R8 restart ack", acks, 3'b111);
    check("R8 restart code", dacCode, 10'h211);
    busStop();

    // R6: address low bits follow addrSel
    addrSel = 2'b01;
    writeByte(7'b0101111, 1'b0, 8'h01, 8'h44, acks);
    check("R6 old address refused", acks, 3'b000);
    check("R6 code kept", dacCode, 10'h211);
    busStop();
    writeByte(7'b0101101, 1'b0, 8'h81, 8'h44, acks);
    check("R6 new address ack", acks, 3'b111);
    check("R3 code after sel", dacCode, 10'h144);
    check("R4 shutdown after sel", shutdown, 1);
    busStop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule